// File: doc/BRIEF.md
# Satellite Switch Tone Signalling Transmitter

This block drives a single carrier-enable output. The output gates an external 22 kHz oscillator, and the block uses it to send commands to satellite switches on the coax line. All timing comes from a one-cycle tick strobe supplied by an external timebase. The block counts these strobes and never counts clock cycles.

While the block is idle, the host writes message bytes into an internal buffer through an address/data/write-enable port. It then presents a message length and a burst-select value and pulses `start`. The block first holds the carrier off for a settling delay. It then sends each byte as nine pulse-width symbols: eight data symbols followed by one odd-parity symbol. When the length is zero, it sends a tone burst instead. At the end it pulses `done`.

Top module: `diseqc_tx`

## Requirements
- R1: While reset is asserted and after it is released, `carrier`, `busy` and `done` are 0.
- R2: A `start` pulse in idle raises `busy` at the next clock edge, with the carrier off. The carrier stays off for the next 15 tick strobes (settling). A strobe that arrives in the same cycle as `start` is not counted.
- R3: Each symbol spans 3 ticks. The carrier is off during the first tick and turns on at its end. For a '1' the carrier goes off after the second tick, giving one tick of carrier. For a '0' it stays on for two ticks. The carrier is off after the third tick.
- R4: Bytes are sent from buffer addresses 0 to length-1 in order. Each byte is sent MSB first, followed by one parity symbol that is '1' when the byte holds an even number of ones. A length above DEPTH (8) is treated as DEPTH.
- R5: Length 0 with `burst_sel` = 0 sends burst A. Burst A is one tick of carrier-off gap, then exactly 25 ticks of continuous carrier, then carrier off.
- R6: Length 0 with `burst_sel` = 1 sends burst B. Burst B is the byte 0xFF sent as a normal byte, which gives nine '1' symbols.
- R7: `done` is a one-cycle pulse at the clock edge that follows the strobe ending the final tick. `busy` falls at that same edge, and the carrier is off.
- R8: A `start` pulse while `busy` is high has no effect on the transfer in progress.
- R9: Buffer writes while `busy` is high are ignored, so the stored bytes stay unchanged.
- R10: The carrier only changes at a clock edge where the tick strobe was sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle timebase strobe, one per tick |
| wr_en | input | 1 | Buffer write enable (acted on only while idle) |
| wr_addr | input | 3 | Buffer write address |
| wr_data | input | 8 | Buffer write data |
| msg_len | input | 4 | Message length in bytes, sampled at start |
| burst_sel | input | 1 | Burst select for empty messages: 0 selects A, 1 selects B |
| start | input | 1 | Start pulse |
| carrier | output | 1 | Carrier enable for the external oscillator |
| busy | output | 1 | High from start until done |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The embedded properties check on every cycle that:
- the carrier is off during idle, settling and each symbol's gap tick;
- the carrier is on during each symbol's second tick;
- the carrier changes only after a tick strobe;
- `done` is single-cycle and never coincides with `busy`.

The following can only be shown by the bench's scenarios, which compare the outputs against a tick-level waveform model on every clock:
- the exact count of settling, carrier and burst ticks;
- MSB-first bit order and odd parity;
- the choice between burst A and burst B;
- clamping of oversized lengths;
- that starts and writes issued during a transfer are ignored.

// File: rtl/diseqc_tx.sv
module diseqc_tx #(
  parameter int DEPTH        = 8,
  parameter int SETTLE_TICKS = 15,
  parameter int BURST_TICKS  = 25,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1),
  localparam int CW = $clog2((SETTLE_TICKS > BURST_TICKS ? SETTLE_TICKS : BURST_TICKS) + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [LW-1:0] msg_len,
  input  logic          burst_sel,
  input  logic          start,
  output logic          carrier,
  output logic          busy,
  output logic          done
);

  typedef enum logic [1:0] {IDLE, SETTLE, SYM, BURST} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic [1:0]    phase;
  logic [3:0]    bit_idx;
  logic [LW-1:0] byte_idx;
  logic [LW-1:0] len_q;
  logic          burst_q;
  logic [7:0]    mem [DEPTH];

  logic [7:0]    cur_byte;
  logic [7:0]    shifted;
  logic          sym_bit;
  logic [LW-1:0] nbytes;
  logic          last_byte;

  assign cur_byte  = (len_q == '0) ? 8'hFF : mem[byte_idx[AW-1:0]];
  assign shifted   = cur_byte << bit_idx[2:0];
  assign sym_bit   = bit_idx[3] ? ~(^cur_byte) : shifted[7];
  assign nbytes    = (len_q == '0) ? LW'(1) : len_q;
  assign last_byte = (byte_idx == nbytes - LW'(1));
  assign busy      = (state != IDLE);

  always_ff @(posedge clk) begin
    if (state == IDLE && wr_en)
      mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= IDLE;
      cnt      <= '0;
      phase    <= '0;
      bit_idx  <= '0;
      byte_idx <= '0;
      len_q    <= '0;
      burst_q  <= 1'b0;
      carrier  <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        IDLE: begin
          carrier <= 1'b0;
          if (start) begin
            state    <= SETTLE;
            cnt      <= '0;
            phase    <= '0;
            bit_idx  <= '0;
            byte_idx <= '0;
            len_q    <= (msg_len > LW'(DEPTH)) ? LW'(DEPTH) : msg_len;
            burst_q  <= burst_sel;
          end
        end
        SETTLE: begin
          if (tick) begin
            if (cnt == CW'(SETTLE_TICKS - 1)) begin
              cnt   <= '0;
              state <= (len_q == '0 && !burst_q) ? BURST : SYM;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
        end
        SYM: begin
          if (tick) begin
            case (phase)
              2'd0: begin
                carrier <= 1'b1;
                phase   <= 2'd1;
              end
              2'd1: begin
                if (sym_bit) carrier <= 1'b0;
                phase <= 2'd2;
              end
              default: begin
                carrier <= 1'b0;
                phase   <= 2'd0;
                if (bit_idx == 4'd8) begin
                  bit_idx <= '0;
                  if (last_byte) begin
                    state <= IDLE;
                    done  <= 1'b1;
                  end else begin
                    byte_idx <= byte_idx + LW'(1);
                  end
                end else begin
                  bit_idx <= bit_idx + 4'd1;
                end
              end
            endcase
          end
        end
        BURST: begin
          if (tick) begin
            if (cnt == CW'(BURST_TICKS)) begin
              carrier <= 1'b0;
              state   <= IDLE;
              done    <= 1'b1;
            end else begin
              if (cnt == '0) carrier <= 1'b1;
              cnt <= cnt + CW'(1);
            end
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

  // R2
  quiet_outside_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == IDLE || state == SETTLE) |-> !carrier);

  // R3
  gap_tick_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SYM && phase == 2'd0) |-> !carrier);

  // R3
  second_tick_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SYM && phase == 2'd1) |-> carrier);

  // R10
  carrier_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (carrier != $past(carrier)) |-> $past(tick));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !carrier));

endmodule

// File: tb/test_diseqc_tx.sv
module test_diseqc_tx;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] msg_len = '0;
  logic       burst_sel = 1'b0;
  logic       start = 1'b0;
  logic       carrier, busy, done;

  diseqc_tx i_diseqc_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .msg_len(msg_len), .burst_sel(burst_sel), .start(start),
    .carrier(carrier), .busy(busy), .done(done)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int dcount = 0;
  int tick_per = 4;
  int tcnt = 0;
  string req = "R1";

  bit exp_carrier = 0, exp_busy = 0, exp_done = 0;
  bit q[$];
  logic [7:0] mmem [8];
  bit last_tick = 0;
  bit prev_carrier = 0;

  task automatic check(input bit ok, input string r, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", r, what, act, exp, $time);
    end
  endtask

  task automatic push_byte(input logic [7:0] b);
    int ones = 0;
    for (int i = 7; i >= 0; i--) begin
      q.push_back(1'b0); q.push_back(1'b1); q.push_back(!b[i]);
      ones += b[i];
    end
    q.push_back(1'b0); q.push_back(1'b1); q.push_back(ones % 2 == 1);
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      tick = 1'b0; tcnt = 0;
    end else begin
      tick = (tcnt == tick_per - 1);
      tcnt = tick ? 0 : tcnt + 1;
    end
  end

  always @(posedge clk) begin
    last_tick <= tick;
    exp_done <= 1'b0;
    if (!rst_n) begin
      exp_carrier <= 0; exp_busy <= 0; q.delete();
    end else if (exp_busy) begin
      if (tick) begin
        void'(q.pop_front());
        if (q.size() == 0) begin
          exp_busy <= 0; exp_done <= 1; exp_carrier <= 0;
        end else begin
          exp_carrier <= q[0];
        end
      end
    end else begin
      if (wr_en) mmem[wr_addr] = wr_data;
      if (start) begin
        int n;
        n = (msg_len > 8) ? 8 : int'(msg_len);
        q.delete();
        for (int i = 0; i < 15; i++) q.push_back(1'b0);
        if (n == 0 && !burst_sel) begin
          q.push_back(1'b0);
          for (int i = 0; i < 25; i++) q.push_back(1'b1);
        end else if (n == 0) begin
          push_byte(8'hFF);
        end else begin
          for (int i = 0; i < n; i++) push_byte(mmem[i]);
        end
        exp_busy <= 1; exp_carrier <= 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(carrier === exp_carrier, req, "carrier", int'(carrier), int'(exp_carrier));
      check(busy === exp_busy, req, "busy", int'(busy), int'(exp_busy));
      check(done === exp_done, req, "done", int'(done), int'(exp_done));
      if (carrier !== prev_carrier)
        check(last_tick, "R10", "carrier change without tick", 0, 1);
      if (done === 1'b1) dcount++;
    end
    prev_carrier = carrier;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic write_byte(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic run(input int len, input bit bsel, input bit disturb);
    int d0;
    int guard;
    d0 = dcount;
    @(negedge clk);
    msg_len = 4'(len); burst_sel = bsel; start = 1;
    @(negedge clk);
    start = 0;
    if (disturb) begin
      repeat (60) @(negedge clk);
      start = 1; msg_len = 4'd0; burst_sel = 0;
      wr_en = 1; wr_addr = 3'd0; wr_data = 8'h5A;
      @(negedge clk);
      start = 0; wr_en = 0;
    end
    guard = 0;
    while (dcount == d0 && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    check(dcount == d0 + 1, "R7", "done pulses", dcount - d0, 1);
    repeat (3) @(negedge clk);
    check(!busy && !carrier, "R7", "idle after done", int'(busy), 0);
    check(dcount == d0 + 1, "R7", "no extra done", dcount - d0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!carrier && !busy && !done, "R1", "outputs in reset", int'({carrier, busy, done}), 0);
    rst_n = 1;
    @(negedge clk);
    check(!carrier && !busy && !done, "R1", "outputs after reset", int'({carrier, busy, done}), 0);

    write_byte(0, 8'hA5);
    req = "R3"; run(1, 0, 0);

    write_byte(0, 8'h3C); write_byte(1, 8'h01); write_byte(2, 8'hFE);
    req = "R4"; run(3, 0, 0);
    req = "R8"; run(3, 0, 1);
    req = "R9"; run(3, 0, 0);

    req = "R5"; run(0, 0, 0);
    req = "R6"; run(0, 1, 0);

    for (int i = 0; i < 8; i++) write_byte(i, 8'(i * 37 + 11));
    req = "R4"; run(12, 0, 0);

    tick_per = 1;
    req = "R2"; run(0, 0, 0);
    tick_per = 3;
    req = "R2"; run(2, 1, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule